// File: doc/BRIEF.md
# Two-Bank Mixed Edge/Level Interrupt Controller

This block collects up to 64 raw interrupt lines into one interrupt request for a processor. The sources sit in two banks of 32. Each bank has a latched event word, an enable word, a write-one-to-clear acknowledge word and a live line-level word, all reached through a simple synchronous register port. A fixed per-bank mask, set by parameter, makes some sources level-sensitive. Those sources are never latched: their synchronized line feeds the pending logic directly. Every other source latches an event on a rising edge of its synchronized line, and the event stays set until software acknowledges it.

A source is pending when its latched event or its masked live level is set and its enable bit is set. The combined request output is high while any source is pending. A registered vector gives the number of the winning source: the highest-numbered pending source wins, so bank 1 (sources 32–63) always beats bank 0. Setting an enable bit never creates an event on its own. An edge source whose line is already high therefore stays quiet after it is enabled, until its line falls and rises again.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Register word addresses (byte offsets, 32-bit data): bank 0 (sources 0–31) at 0x20, bank 1 (sources 32–63) at 0x10. Within a bank, event is at +0x0, enable at +0x4, acknowledge at +0x8 and live level at +0xC. Source n uses bank n>>5, bit n&31. The vector register is at 0x00.
- R2: An edge source sets its event bit one synchronizer delay after a rising edge on its line, whether or not it is enabled. The bit stays set after the line falls, until it is acknowledged.
- R3: Writing the acknowledge word clears the event bits written as 1 and leaves the bits written as 0 untouched.
- R4: Sources whose bit is set in the bank's level mask (default 0x3FF00000 for bank 0, 0x1FF00000 for bank 1) never set an event bit. While enabled they are pending exactly while their synchronized line is high.
- R5: The enable word reads back exactly the last value written. Writes to the event, level and vector words change nothing.
- R6: Source pending = (event | (level & mask)) & enable. irq_o is high, one cycle after the pending state settles, while any source is pending.
- R7: The vector picks the highest-numbered pending source, so any bank-1 source beats any bank-0 source. It reads as bit 6 = valid and bits 5:0 = source number. It is also driven on vec_valid_o and vec_id_o.
- R8: Enabling an edge source whose event bit is clear while its line is held high does not assert irq_o or set the event bit.
- R9: After reset, all enable and event bits are zero, irq_o is low and the vector is invalid.
- R10: The level word returns the synchronized state of all 32 lines of the bank, whether they are edge or level sources.
- R11: Reads of unmapped or misaligned addresses return zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 64 | Raw asynchronous interrupt lines, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe, data appears the next cycle |
| addr_i | input | 6 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| vec_valid_o | output | 1 | A pending source exists |
| vec_id_o | output | 6 | Number of the winning pending source |

## Verification
Edge sources are driven with a rise while disabled, a fall after latching, and a rise held high across an acknowledge. These cases separate edge latching from level following, and show whether enabling creates events. A level-masked source is raised before it is enabled and then dropped. This shows live pass-through and that such a source never latches. Sources are raised one at a time in both banks, some with a higher bit in bank 0 than the bank-1 source, and acknowledged in reverse order. The vector must then step through each winner, which separates bank order from bit order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int SRC_N     = BANK_W * NUM_BANKS;
  localparam int ID_W      = $clog2(SRC_N);
  localparam int ADDR_W    = 6;

  typedef enum logic [1:0] {
    WSEL_EVENT  = 2'd0,
    WSEL_ENABLE = 2'd1,
    WSEL_ACK    = 2'd2,
    WSEL_LEVEL  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] id;
  } vec_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  AST_RISE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((rise_o & $past(lvl_o)) == '0)); // R2
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int          W        = 32,
  parameter logic [31:0] LVL_MASK = 32'h3FF0_0000
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  localparam logic [W-1:0] LMASK = LVL_MASK[W-1:0];
  localparam logic [W-1:0] EMASK = ~LMASK;

  logic [W-1:0] evt_q, en_q, clr_mask, held, evt_d;

  assign clr_mask = ack_we_i ? wdata_i : '0;
  assign held     = evt_q & ~clr_mask;
  assign evt_d    = held | (rise_i & EMASK);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= evt_d;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign evt_o  = evt_q;
  assign en_o   = en_q;
  assign pend_o = (evt_q | (lvl_i & LMASK)) & en_q;

  AST_ENABLE_READBACK: assert property (@(posedge clk_i) disable iff (rst_i)
    en_we_i |=> (en_o == $past(wdata_i))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_we_i |=> ((evt_q & $past(wdata_i & ~rise_i)) == '0)); // R3
  AST_EVENT_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((evt_q & $past(held)) == $past(held))); // R2
  AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(rise_i)) == '0)); // R8
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [N-1:0]         req_i,
  output logic                 valid_o,
  output logic [$clog2(N)-1:0] id_o
);
  localparam int IW = $clog2(N);

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        id_o    = IW'(i);
      end
    end
  end

  AST_WINNER_IS_HIGHEST: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (((req_i >> id_o) >> 1) == '0)); // R7
  AST_WINNER_REQUESTS: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> req_i[id_o]); // R7
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] LVL_MASK_B0 = 32'h3FF0_0000,
  parameter logic [31:0] LVL_MASK_B1 = 32'h1FF0_0000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SRC_N-1:0]  irq_lines_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              vec_valid_o,
  output logic [ID_W-1:0]   vec_id_o
);
  localparam logic [SRC_N-1:0] LVL_MASKS = {LVL_MASK_B1[BANK_W-1:0], LVL_MASK_B0[BANK_W-1:0]};

  logic [SRC_N-1:0] lvl_sync, rise, evt_all, en_all, pend_all;
  logic [NUM_BANKS-1:0] bank_hit;
  logic aligned, vec_hit, win_valid;
  logic [ID_W-1:0] win_id;
  wsel_e wsel;
  vec_t vec_q;
  logic irq_q;
  logic [BANK_W-1:0] rdata_q, rd_mux;

  irqc_sync #(.W(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (irq_lines_i),
    .lvl_o   (lvl_sync),
    .rise_o  (rise)
  );

  assign aligned = (addr_i[1:0] == 2'b00);
  assign vec_hit = aligned && (addr_i[ADDR_W-1:2] == '0);
  assign wsel    = wsel_e'(addr_i[3:2]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = aligned && (addr_i[5:4] == 2'(NUM_BANKS - b));

    irqc_bank #(
      .W        (BANK_W),
      .LVL_MASK (LVL_MASKS[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .lvl_i    (lvl_sync[b*BANK_W +: BANK_W]),
      .rise_i   (rise[b*BANK_W +: BANK_W]),
      .en_we_i  (wr_en_i && bank_hit[b] && (wsel == WSEL_ENABLE)),
      .ack_we_i (wr_en_i && bank_hit[b] && (wsel == WSEL_ACK)),
      .wdata_i  (wdata_i),
      .evt_o    (evt_all[b*BANK_W +: BANK_W]),
      .en_o     (en_all[b*BANK_W +: BANK_W]),
      .pend_o   (pend_all[b*BANK_W +: BANK_W])
    );
  end

  irqc_prio #(.N(SRC_N)) u_prio (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (pend_all),
    .valid_o (win_valid),
    .id_o    (win_id)
  );

  always_comb begin
    rd_mux = '0;
    if (vec_hit) rd_mux = BANK_W'(vec_q);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (wsel)
          WSEL_EVENT:  rd_mux = evt_all[b*BANK_W +: BANK_W];
          WSEL_ENABLE: rd_mux = en_all[b*BANK_W +: BANK_W];
          WSEL_LEVEL:  rd_mux = lvl_sync[b*BANK_W +: BANK_W];
          default:     rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      irq_q       <= |pend_all;
      vec_q.valid <= win_valid;
      vec_q.id    <= win_id;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign irq_o       = irq_q;
  assign vec_valid_o = vec_q.valid;
  assign vec_id_o    = vec_q.id;
  assign rdata_o     = rdata_q;

  AST_VEC_TRACKS_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
    vec_valid_o |-> irq_o); // R6
endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] lines = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        vvalid;
  logic [5:0]  vid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl i_banked_irq_ctrl (
    .clk_i       (clk),
    .rst_i       (rst),
    .irq_lines_i (lines),
    .wr_en_i     (wr_en),
    .rd_en_i     (rd_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .irq_o       (irq),
    .vec_valid_o (vvalid),
    .vec_id_o    (vid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] vec_word();
    return {25'b0, vvalid, vid};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h24, d); chk("R9 bank0 enable after reset", d, 32'h0);
    rd(6'h14, d); chk("R9 bank1 enable after reset", d, 32'h0);
    rd(6'h20, d); chk("R9 bank0 event after reset", d, 32'h0);
    chk("R9 irq low after reset", {31'b0, irq}, 32'h0);
    chk("R9 vector invalid after reset", vec_word(), 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(6'h24, 32'hA5A5_0F0F);
    rd(6'h24, d); chk("R5 bank0 enable readback", d, 32'hA5A5_0F0F);
    rd(6'h14, d); chk("R1 bank1 enable untouched", d, 32'h0);
    wr(6'h14, 32'h1234_5678);
    rd(6'h14, d); chk("R1 bank1 enable readback", d, 32'h1234_5678);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, d); chk("R5 event write ignored", d, 32'h0);
    rd(6'h04, d); chk("R11 unmapped read zero", d, 32'h0);
    wr(6'h25, 32'h0);
    rd(6'h24, d); chk("R11 misaligned write ignored", d, 32'hA5A5_0F0F);
    wr(6'h24, 32'h0);
    wr(6'h14, 32'h0);
    chk("R6 no lines no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    lines[3] = 1'b1; settle();
    rd(6'h20, d); chk("R2 edge latched while disabled", d, 32'h8);
    chk("R6 disabled source no irq", {31'b0, irq}, 32'h0);
    wr(6'h24, 32'h8); settle();
    chk("R6 enabled event raises irq", {31'b0, irq}, 32'h1);
    chk("R7 vector source 3", vec_word(), 32'h43);
    rd(6'h00, d); chk("R1 vector register read", d, 32'h43);
    lines[3] = 1'b0; settle();
    rd(6'h20, d); chk("R2 event holds after line falls", d, 32'h8);
    chk("R2 irq holds after line falls", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_ack_quirk();
    logic [31:0] d;
    wr(6'h28, 32'h0);
    rd(6'h20, d); chk("R3 ack zero no effect", d, 32'h8);
    wr(6'h28, 32'h8); settle();
    rd(6'h20, d); chk("R3 ack clears event", d, 32'h0);
    chk("R3 irq drops after ack", {31'b0, irq}, 32'h0);
    wr(6'h24, 32'h0);
    lines[3] = 1'b1; settle();
    wr(6'h28, 32'h8);
    wr(6'h24, 32'h8); settle();
    chk("R8 enable on high line no irq", {31'b0, irq}, 32'h0);
    rd(6'h20, d); chk("R8 enable on high line no event", d, 32'h0);
    lines[3] = 1'b0; settle();
    lines[3] = 1'b1; settle();
    chk("R8 later edge raises irq", {31'b0, irq}, 32'h1);
    wr(6'h24, 32'h0);
    wr(6'h28, 32'h8);
    lines[3] = 1'b0; settle();
  endtask

  task automatic t_level();
    logic [31:0] d;
    lines[20] = 1'b1; lines[7] = 1'b1; settle();
    rd(6'h2C, d); chk("R10 level word live", d, 32'h0010_0080);
    rd(6'h20, d); chk("R4 level source never latches", d, 32'h0000_0080);
    wr(6'h24, 32'h0010_0000); settle();
    chk("R4 level source passes after enable", {31'b0, irq}, 32'h1);
    chk("R7 vector level source 20", vec_word(), 32'h54);
    lines[20] = 1'b0; settle();
    chk("R4 level source drops with line", {31'b0, irq}, 32'h0);
    wr(6'h24, 32'h0);
    wr(6'h28, 32'h80);
    lines[7] = 1'b0; settle();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(6'h24, 32'h8000_0020);
    wr(6'h14, 32'h0000_0102);
    lines[5] = 1'b1; lines[31] = 1'b1; settle();
    chk("R7 highest bit in bank0", vec_word(), 32'h5F);
    lines[33] = 1'b1; settle();
    chk("R7 bank1 beats bank0", vec_word(), 32'h61);
    lines[40] = 1'b1; settle();
    chk("R7 highest bank1 source", vec_word(), 32'h68);
    rd(6'h1C, d); chk("R10 bank1 level word", d, 32'h0000_0102);
    wr(6'h18, 32'h100); settle();
    chk("R7 after ack of 40", vec_word(), 32'h61);
    wr(6'h18, 32'h2); settle();
    chk("R7 after ack of 33", vec_word(), 32'h5F);
    rd(6'h00, d); chk("R7 vector register", d, 32'h5F);
    wr(6'h28, 32'h8000_0020); settle();
    chk("R6 all acked irq low", {31'b0, irq}, 32'h0);
    chk("R7 vector invalid when idle", vec_word(), 32'h0);
    lines = '0; settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_edge();
    t_ack_quirk();
    t_level();
    t_prio();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule